// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block collects a large set of peripheral interrupt lines and reduces them to a single summary request for a host processor. The lines are grouped eight to a block, and blocks are grouped into master groups. A three-level status tree (root, master, block) lets host software find the source of an interrupt by walking down from the root in a few byte reads, without scanning every line.

Each line passes through a synchroniser. It can then be set to trigger on a rising edge, a falling edge, both edges, a high level or a low level, or it can be disabled. When its trigger fires it latches a pending bit. The host reaches the setup of each line indirectly. It first writes a block number to a selector register. It then writes a packed configuration byte that names one line inside that block and carries its mode, its masks and a clear command. The same selector picks which block's latched pending bits and live input levels are returned by the two per-block status addresses.

The register window is byte wide and sits in a 10-bit address space at a parameterised base address. Read data is registered, so it appears on the cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every pending bit is 0, every line has both masks set in edge mode, irq_out is 0, and the root, master and selector registers read 0.
- R2: With base B = 0x1BB the registers are B+0 root status, B+1..B+4 master status 1..4, B+5 block selector (read/write, low 5 bits), B+6 block pending status, B+7 configuration, B+8 block live status. Reads of the configuration address or of any address outside the window return 0. The selector changes only when it is written.
- R3: A write to the configuration address takes effect only when bit 7 is 1. It targets line sel*8+wdata[6:4], where sel is the current selector value. Its bit 0 selects level mode, bit 1 masks the falling edge (or the low level), and bit 2 masks the rising edge (or the high level).
- R4: In edge mode, each cleared mask enables its matching edge of the input after a two-flop synchroniser. A qualifying edge applied before clock edge k shows as pending after clock edge k+2. An input that does not change never sets a pending bit in edge mode.
- R5: In level mode, a cleared bit 2 triggers on a high input and a cleared bit 1 triggers on a low input. If the active level is still present, a pending bit that was cleared is set again on the next clock.
- R6: A configuration write with bit 7 and bit 3 set clears the targeted line's pending bit at that clock.
- R7: A line with both masks set latches no new pending bit. A pending bit that is already latched on such a line is left out of the master status, the root status and irq_out, but it is still shown in the block pending status.
- R8: A read of B+6 returns the latched pending bits of the selected block, with bit i for line sel*8+i. A read of B+8 returns the synchronised input levels of that block. Read data is registered one cycle after rd_en and holds while rd_en is low.
- R9: Master m bit i is 1 when block m*8+i holds a pending bit on a line that is not disabled. Root bit m+1 is the OR of master m, root bit 0 is always 0, and irq_out is the OR of the root bits.
- R10: Writes to the root, master, block pending and live status addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 256 | Asynchronous interrupt source lines |
| addr | input | 10 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Summary interrupt request to the host |

## Verification
On every cycle, the assertions check four things. A clear command empties the targeted pending bit. A disabled line, or an edge-mode line with a steady input, never gains a pending bit. The summary output follows the master tree. The selector and the read data hold unless they are strobed. Only the bench's scenarios can show the rest. These are the mapping of each of the 256 lines to the right block, master and root bit, the exact latency through the synchroniser, the re-pend of a still-active level line one cycle after a clear, the rejection of configuration writes that lack bit 7, and the absence of any effect from writes to status addresses.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   typedef struct packed {
      logic lvl;
      logic mask_fall;
      logic mask_rise;
   } line_cfg_t;

   localparam line_cfg_t CFG_RESET = '{lvl: 1'b0, mask_fall: 1'b1, mask_rise: 1'b1};

   localparam int CFG_LVL_BIT   = 0;
   localparam int CFG_MFALL_BIT = 1;
   localparam int CFG_MRISE_BIT = 2;
   localparam int CFG_CLR_BIT   = 3;
   localparam int CFG_LINE_LSB  = 4;
   localparam int CFG_ARM_BIT   = 7;

   function automatic line_cfg_t cfg_from_byte(input logic [7:0] b);
      line_cfg_t c;
      c.lvl       = b[CFG_LVL_BIT];
      c.mask_fall = b[CFG_MFALL_BIT];
      c.mask_rise = b[CFG_MRISE_BIT];
      return c;
   endfunction

endpackage

// File: rtl/irqagg_line.sv
module irqagg_line
   import irqagg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      raw_i,
   input  logic      cfg_we_i,
   input  line_cfg_t cfg_i,
   input  logic      clr_i,
   output logic      pend_o,
   output logic      en_o,
   output logic      lvl_o
);

   logic      s_now;
   logic      s_prev;
   line_cfg_t cfg_q;
   logic      evt;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign s_now = raw_i;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= 1'b0;
         else        sh <= raw_i;
      end
      assign s_now = sh;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-2:0], raw_i};
      end
      assign s_now = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_prev <= 1'b0;
         cfg_q  <= CFG_RESET;
      end else begin
         s_prev <= s_now;
         if (cfg_we_i) cfg_q <= cfg_i;
      end
   end

   always_comb begin
      if (cfg_q.lvl)
         evt = (!cfg_q.mask_rise && s_now) || (!cfg_q.mask_fall && !s_now);
      else
         evt = (!cfg_q.mask_rise && s_now && !s_prev) ||
               (!cfg_q.mask_fall && !s_now && s_prev);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend_o <= 1'b0;
      else if (cfg_we_i && clr_i) pend_o <= 1'b0;
      else if (evt)               pend_o <= 1'b1;
   end

   assign en_o  = !(cfg_q.mask_rise && cfg_q.mask_fall);
   assign lvl_o = s_now;

   // R6
   clr_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && clr_i) |=> !pend_o);

   // R7
   disabled_no_new_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_o && cfg_q.mask_rise && cfg_q.mask_fall) |=> !pend_o);

   // R4
   steady_edge_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_o && !cfg_q.lvl && (s_now == s_prev)) |=> !pend_o);

endmodule

// File: rtl/irqagg_tree.sv
module irqagg_tree #(
   parameter int NUM_BLKS      = 32,
   parameter int BLKS_PER_MST  = 8,
   localparam int NUM_MST      = (NUM_BLKS + BLKS_PER_MST - 1) / BLKS_PER_MST
) (
   input  logic [NUM_BLKS-1:0]  blk_any_i,
   output logic [NUM_MST*8-1:0] mst_o,
   output logic [7:0]           root_o,
   output logic                 irq_o
);

   for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
      for (genvar i = 0; i < 8; i++) begin : g_bit
         if ((i < BLKS_PER_MST) && (m * BLKS_PER_MST + i < NUM_BLKS)) begin : g_used
            assign mst_o[m*8+i] = blk_any_i[m*BLKS_PER_MST+i];
         end else begin : g_unused
            assign mst_o[m*8+i] = 1'b0;
         end
      end
   end

   always_comb begin
      root_o = '0;
      for (int m = 0; m < NUM_MST; m++) root_o[m+1] = |mst_o[m*8 +: 8];
   end

   assign irq_o = |root_o;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqagg_pkg::*;
#(
   parameter int              NUM_LINES    = 256,
   parameter int              LINES_PER_BLK = 8,
   parameter int              BLKS_PER_MST = 8,
   parameter int              ADDR_W       = 10,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 10'h1BB,
   parameter int              SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [7:0]           wdata,
   input  logic                 rd_en,
   output logic [7:0]           rdata,
   output logic                 irq_out
);

   localparam int NUM_BLKS = NUM_LINES / LINES_PER_BLK;
   localparam int NUM_MST  = (NUM_BLKS + BLKS_PER_MST - 1) / BLKS_PER_MST;
   localparam int SEL_W    = $clog2(NUM_BLKS);
   localparam logic [ADDR_W-1:0] OFF_ROOT = '0;
   localparam logic [ADDR_W-1:0] OFF_SEL  = ADDR_W'(NUM_MST + 1);
   localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(NUM_MST + 2);
   localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(NUM_MST + 3);
   localparam logic [ADDR_W-1:0] OFF_LIVE = ADDR_W'(NUM_MST + 4);

   initial begin
      assert (LINES_PER_BLK == 8) else $error("a block must hold one byte of lines");
      assert (BLKS_PER_MST >= 1 && BLKS_PER_MST <= 8) else $error("master holds 1..8 blocks");
      assert (NUM_BLKS >= 2 && NUM_BLKS == (1 << SEL_W)) else $error("block count must be a power of two");
      assert (NUM_MST <= 7) else $error("root byte fits at most 7 masters");
      assert (SYNC_STAGES >= 0) else $error("negative synchroniser depth");
   end

   logic [SEL_W-1:0]     blk_sel;
   logic [ADDR_W-1:0]    off;
   logic                 in_win;
   logic                 cfg_wr;
   line_cfg_t            cfg_new;
   logic [7:0]           blk_pend [NUM_BLKS];
   logic [7:0]           blk_en   [NUM_BLKS];
   logic [7:0]           blk_lvl  [NUM_BLKS];
   logic [NUM_BLKS-1:0]  blk_any;
   logic [NUM_MST*8-1:0] mst_bits;
   logic [7:0]           root;
   logic [7:0]           rd_val;

   assign off     = addr - BASE_ADDR;
   assign in_win  = (addr >= BASE_ADDR) && (off <= OFF_LIVE);
   assign cfg_wr  = wr_en && in_win && (off == OFF_CFG) && wdata[CFG_ARM_BIT];
   assign cfg_new = cfg_from_byte(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 blk_sel <= '0;
      else if (wr_en && in_win && off == OFF_SEL) blk_sel <= wdata[SEL_W-1:0];
   end

   for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
      for (genvar i = 0; i < 8; i++) begin : g_line
         logic hit;
         assign hit = cfg_wr && (blk_sel == SEL_W'(b)) &&
                      (wdata[CFG_LINE_LSB +: 3] == 3'(i));
         irqagg_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (irq_in[b*8+i]),
            .cfg_we_i (hit),
            .cfg_i    (cfg_new),
            .clr_i    (wdata[CFG_CLR_BIT]),
            .pend_o   (blk_pend[b][i]),
            .en_o     (blk_en[b][i]),
            .lvl_o    (blk_lvl[b][i])
         );
      end
      assign blk_any[b] = |(blk_pend[b] & blk_en[b]);
   end

   irqagg_tree #(.NUM_BLKS(NUM_BLKS), .BLKS_PER_MST(BLKS_PER_MST)) u_tree (
      .blk_any_i (blk_any),
      .mst_o     (mst_bits),
      .root_o    (root),
      .irq_o     (irq_out)
   );

   always_comb begin
      rd_val = '0;
      if (in_win) begin
         if (off == OFF_ROOT) rd_val = root;
         for (int m = 0; m < NUM_MST; m++)
            if (off == ADDR_W'(m + 1)) rd_val = mst_bits[m*8 +: 8];
         if (off == OFF_SEL)  rd_val = 8'(blk_sel);
         if (off == OFF_PEND) rd_val = blk_pend[blk_sel];
         if (off == OFF_LIVE) rd_val = blk_lvl[blk_sel];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   // R9
   irq_tracks_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (|mst_bits));

   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && in_win && off == OFF_SEL) |=> $stable(blk_sel));

   // R8
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

   localparam int A_ROOT = 'h1BB;
   localparam int A_SEL  = 'h1C0;
   localparam int A_PEND = 'h1C1;
   localparam int A_CFG  = 'h1C2;
   localparam int A_LIVE = 'h1C3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] irq_in = '0;
   logic [9:0]   addr = '0;
   logic         wr_en = 1'b0;
   logic [7:0]   wdata = '0;
   logic         rd_en = 1'b0;
   logic [7:0]   rdata;
   logic         irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_aggregator u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
      .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = 10'(a); wdata = 8'(d); wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      addr = 10'(a); rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
      d = int'(rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg_line(input int line, input int bits);
      wr(A_SEL, line / 8);
      wr(A_CFG, 'h80 | ((line % 8) << 4) | bits);
   endtask

   initial begin
      int v;
      int blk;
      int b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 irq_out", int'(irq_out), 0);
      rd(A_ROOT, v); chk("R1 root", v, 0);
      rd(A_SEL, v);  chk("R1 selector", v, 0);
      for (int m = 0; m < 4; m++) begin
         rd(A_ROOT + 1 + m, v); chk("R1 master", v, 0);
      end
      // R1 all lines disabled: an edge on every line latches nothing
      irq_in = '1; idle(4);
      for (int k = 0; k < 32; k++) begin
         wr(A_SEL, k); rd(A_PEND, v); chk("R1 pend after edge on disabled line", v, 0);
         rd(A_LIVE, v); chk("R8 live level", v, 'hFF);
      end
      chk("R1 irq_out quiet", int'(irq_out), 0);
      irq_in = '0; idle(4);

      // R2 reads outside window and of config address
      rd('h000, v); chk("R2 unmapped read", v, 0);
      rd('h1C4, v); chk("R2 past window", v, 0);
      rd(A_CFG, v); chk("R2 config reads zero", v, 0);
      wr(A_SEL, 'h13); rd(A_SEL, v); chk("R2 selector readback", v, 'h13);

      // R4 R8 R9 R6 sweep over every line with rising-edge trigger
      for (int ln = 0; ln < 256; ln++) begin
         blk = ln / 8; b = ln % 8;
         cfg_line(ln, 'h02);
         irq_in[ln] = 1'b1;
         idle(4);
         rd(A_PEND, v);             chk("R4 rising pend", v, 1 << b);
         rd(A_ROOT + 1 + blk / 8, v); chk("R9 master bit", v, 1 << (blk % 8));
         rd(A_ROOT, v);             chk("R9 root bit", v, 1 << (blk / 8 + 1));
         chk("R9 irq_out high", int'(irq_out), 1);
         irq_in[ln] = 1'b0;
         wr(A_CFG, 'h80 | (b << 4) | 'h0E);
         idle(3);
         rd(A_PEND, v);             chk("R6 cleared", v, 0);
         chk("R9 irq_out low", int'(irq_out), 0);
      end

      // R4 exact latency: edge before clock k visible after k+2
      cfg_line(3, 'h02);
      @(negedge clk); irq_in[3] = 1'b1;
      @(posedge clk); #1; chk("R4 not yet after k", int'(irq_out), 0);
      @(posedge clk); #1; chk("R4 not yet after k+1", int'(irq_out), 0);
      @(posedge clk); #1; chk("R4 set after k+2", int'(irq_out), 1);
      irq_in[3] = 1'b0;
      wr(A_CFG, 'h80 | (3 << 4) | 'h0E);

      // R4 falling edge, steady high no pend
      irq_in[37] = 1'b1; idle(4);
      cfg_line(37, 'h04);
      idle(4);
      rd(A_PEND, v); chk("R4 steady high no pend", v, 0);
      irq_in[37] = 1'b0; idle(4);
      rd(A_PEND, v); chk("R4 falling pend", v, 1 << 5);
      wr(A_CFG, 'h80 | (5 << 4) | 'h0E);

      // R5 level high, re-pend after clear
      irq_in[100] = 1'b1;
      cfg_line(100, 'h03);
      idle(4);
      rd(A_PEND, v); chk("R5 level high pend", v, 1 << 4);
      wr(A_CFG, 'h80 | (4 << 4) | 'h0B);
      rd(A_PEND, v); chk("R5 cleared first cycle", v, 0);
      rd(A_PEND, v); chk("R5 re-pend next cycle", v, 1 << 4);
      irq_in[100] = 1'b0;
      wr(A_CFG, 'h80 | (4 << 4) | 'h0E);

      // R5 level low
      cfg_line(200, 'h05);
      idle(3);
      rd(A_PEND, v); chk("R5 level low pend", v, 1 << 0);
      rd(A_ROOT, v); chk("R9 root for master 3", v, 1 << 4);
      wr(A_CFG, 'h80 | (0 << 4) | 'h0E);

      // R3 write without bit 7 ignored
      wr(A_SEL, 0);
      wr(A_CFG, (5 << 4) | 'h02);
      irq_in[5] = 1'b1; idle(4);
      rd(A_PEND, v); chk("R3 unarmed write ignored", v, 0);
      chk("R3 irq_out stays low", int'(irq_out), 0);
      irq_in[5] = 1'b0; idle(4);

      // R3 line field selects within block
      cfg_line(14, 'h02);
      irq_in[13] = 1'b1; irq_in[14] = 1'b1; idle(4);
      rd(A_PEND, v); chk("R3 only targeted line", v, 1 << 6);
      irq_in[13] = 1'b0; irq_in[14] = 1'b0;
      wr(A_CFG, 'h80 | (6 << 4) | 'h0E);

      // R7 disable with pending latched
      cfg_line(9, 'h02);
      irq_in[9] = 1'b1; idle(4);
      wr(A_CFG, 'h80 | (1 << 4) | 'h06);
      rd(A_PEND, v); chk("R7 pend kept", v, 1 << 1);
      rd(A_ROOT + 1, v); chk("R7 master excludes disabled", v, 0);
      chk("R7 irq_out low", int'(irq_out), 0);
      wr(A_CFG, 'h80 | (1 << 4) | 'h0E);
      irq_in[9] = 1'b0; idle(3);

      // R10 writes to status addresses ignored
      cfg_line(17, 'h02);
      irq_in[17] = 1'b1; idle(4);
      wr(A_ROOT, 'h00); wr(A_ROOT + 1, 'h00); wr(A_PEND, 'h00); wr(A_LIVE, 'h00);
      rd(A_SEL, v);  chk("R10 selector unchanged", v, 2);
      rd(A_PEND, v); chk("R10 pend unchanged", v, 1 << 1);
      rd(A_ROOT, v); chk("R10 root unchanged", v, 'h02);
      chk("R10 irq_out unchanged", int'(irq_out), 1);
      irq_in[17] = 1'b0;
      wr(A_CFG, 'h80 | (1 << 4) | 'h0E);
      idle(3);
      rd(A_ROOT, v); chk("R9 root bit0 zero", v, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule